// File: doc/BRIEF.md
# In-Order Commit Queue with Flush

This block tracks instructions between issue and commit in an out-of-order core. The front end places each instruction into a circular ring of slots in program order. Execution units later report results out of order, naming the slot they belong to. The block commits strictly from the oldest slot, and only after that slot's result has arrived. Each commit drives one register-file write port with the slot's destination register and value.

Two events cut the speculative tail of the ring. The first is a mispredicted branch, reported with its completion. It drops every slot younger than the branch in the same cycle. The branch itself stays and commits normally. The second is a fault flag on the oldest completed slot. That slot is never committed, and the whole ring is emptied. Both events raise a one-cycle redirect towards fetch, carrying a cause code and a target PC.

Top module: `rob_core`

## Requirements
- R1: After reset the ring is empty. `alloc_ready` is 1, `alloc_idx` is 0, and neither `rf_we` nor `redirect_valid` is asserted.
- R2: An allocation is taken when `alloc_valid` and `alloc_ready` are both high. It lands in slot `alloc_idx`, and `alloc_idx` advances by one, wrapping from DEPTH-1 to 0.
- R3: With DEPTH-1 slots occupied (the next tail equals the head), `alloc_ready` is 0. This holds even in a cycle in which the oldest slot commits.
- R4: A completion stores its value in the named slot and marks the slot done. It never asserts `rf_we` in its own cycle.
- R5: While the oldest slot is done and has no fault, `rf_we` is 1, with `rf_addr`/`rf_data` equal to that slot's destination and value. The slot is freed at the next edge, so at most one slot commits per cycle.
- R6: A done slot never commits while any older slot is not yet done.
- R7: If the oldest slot is done with its fault flag set, it does not commit. In that cycle: `redirect_valid`=1, `redirect_cause`=1, `redirect_pc` is the slot's PC, and `alloc_ready`=0. From the next cycle the ring is empty and `alloc_idx` equals the old head slot.
- R8: A completion with `cmp_misp`=1 to an occupied slot k raises, in that cycle: `redirect_valid`=1, `redirect_cause`=2, `redirect_pc`=`cmp_target`, and `alloc_ready`=0. Every slot younger than k is dropped, the next `alloc_idx` is k+1, and slot k later commits.
- R9: A completion to a slot that is free or has been dropped is ignored. It raises no redirect, and the slot never commits.
- R10: When a fault at the oldest slot and a mispredict completion occur in the same cycle, only the fault is reported (cause 1), and the completion is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Request to place a new instruction |
| alloc_dest | input | REG_W | Destination register of the new instruction |
| alloc_pc | input | PC_W | PC of the new instruction |
| alloc_ready | output | 1 | Ring can take an instruction this cycle |
| alloc_idx | output | IDX_W | Slot the next instruction receives |
| cmp_valid | input | 1 | Completion report valid |
| cmp_idx | input | IDX_W | Slot being completed |
| cmp_value | input | DATA_W | Result value |
| cmp_exc | input | 1 | Instruction faulted |
| cmp_misp | input | 1 | Branch was mispredicted |
| cmp_target | input | PC_W | Correct fetch target for a mispredict |
| rf_we | output | 1 | Register-file write enable (commit) |
| rf_addr | output | REG_W | Register-file write address |
| rf_data | output | DATA_W | Register-file write data |
| redirect_valid | output | 1 | Fetch redirect |
| redirect_cause | output | 2 | 1 = fault, 2 = mispredict |
| redirect_pc | output | PC_W | Redirect target |

## Verification
The hardest state to reach is a same-cycle collision. A fault at the oldest slot has to coincide with a mispredict report on a younger slot, or a commit has to coincide with an allocation attempt while the ring is full. Each of these needs a precise history of allocations and completions first. The bench reaches them with directed sequences that fill the ring to capacity and then time completions to land in the commit cycle. After that, biased random traffic completes slots in arbitrary order and injects occasional faults and mispredicts. It also sends completions to slots that were just dropped, and checks each of these against a bench-side model of the ring.

// File: rtl/rob_pkg.sv
package rob_pkg;
  typedef enum logic [1:0] {
    REDIR_NONE   = 2'd0,
    REDIR_FAULT  = 2'd1,
    REDIR_BRANCH = 2'd2
  } redir_cause_e;
endpackage

// File: rtl/rob_ptrs.sv
module rob_ptrs #(
  parameter int DEPTH = 8,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv_head,
  input  logic             adv_tail,
  input  logic             flush_all,
  input  logic             trim,
  input  logic [IDX_W-1:0] trim_idx,
  output logic [IDX_W-1:0] head,
  output logic [IDX_W-1:0] tail,
  output logic             full,
  output logic             empty
);
  function automatic logic [IDX_W-1:0] ring_next(input logic [IDX_W-1:0] p);
    return (p == IDX_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head <= '0;
      tail <= '0;
    end else begin
      if (adv_head) head <= ring_next(head);
      if (flush_all)     tail <= head;
      else if (trim)     tail <= ring_next(trim_idx);
      else if (adv_tail) tail <= ring_next(tail);
    end
  end

  assign full  = (ring_next(tail) == head);
  assign empty = (head == tail);

  // R3: the controller never pushes into a full ring
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    adv_tail |-> !full);
  // R5: commits never happen from an empty ring
  p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    adv_head |-> !empty);
endmodule

// File: rtl/rob_slots.sv
module rob_slots #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  parameter int REG_W  = 5,
  parameter int PC_W   = 32,
  parameter int IDX_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_we,
  input  logic [IDX_W-1:0]  alloc_idx,
  input  logic [REG_W-1:0]  alloc_dest,
  input  logic [PC_W-1:0]   alloc_pc,
  input  logic              cmp_we,
  input  logic [IDX_W-1:0]  cmp_idx,
  input  logic [DATA_W-1:0] cmp_value,
  input  logic              cmp_exc,
  input  logic              free_we,
  input  logic [IDX_W-1:0]  free_idx,
  input  logic [DEPTH-1:0]  kill,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DEPTH-1:0]  slot_valid,
  output logic              rd_done,
  output logic              rd_exc,
  output logic [REG_W-1:0]  rd_dest,
  output logic [DATA_W-1:0] rd_value,
  output logic [PC_W-1:0]   rd_pc
);
  logic [DEPTH-1:0]  valid_q, done_q, exc_q;
  logic [REG_W-1:0]  dest_q  [DEPTH];
  logic [DATA_W-1:0] value_q [DEPTH];
  logic [PC_W-1:0]   pc_q    [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      done_q  <= '0;
      exc_q   <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (kill[i] || (free_we && free_idx == IDX_W'(i)))
          valid_q[i] <= 1'b0;
        else if (alloc_we && alloc_idx == IDX_W'(i))
          valid_q[i] <= 1'b1;
        if (alloc_we && alloc_idx == IDX_W'(i)) begin
          done_q[i] <= 1'b0;
          exc_q[i]  <= 1'b0;
        end else if (cmp_we && cmp_idx == IDX_W'(i)) begin
          done_q[i] <= 1'b1;
          exc_q[i]  <= cmp_exc;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (alloc_we && alloc_idx == IDX_W'(i)) begin
        dest_q[i] <= alloc_dest;
        pc_q[i]   <= alloc_pc;
      end
      if (cmp_we && cmp_idx == IDX_W'(i)) value_q[i] <= cmp_value;
    end
  end

  assign slot_valid = valid_q;
  assign rd_done    = done_q[rd_idx];
  assign rd_exc     = exc_q[rd_idx];
  assign rd_dest    = dest_q[rd_idx];
  assign rd_value   = value_q[rd_idx];
  assign rd_pc      = pc_q[rd_idx];

  // R9: completions only land on occupied slots
  p_cmp_on_live_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_we |-> valid_q[cmp_idx]);
  // R2: allocation only reuses a free slot
  p_alloc_free_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_we |-> !valid_q[alloc_idx]);
endmodule

// File: rtl/rob_core.sv
module rob_core #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  parameter int REG_W  = 5,
  parameter int PC_W   = 32,
  parameter int IDX_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  input  logic [REG_W-1:0]  alloc_dest,
  input  logic [PC_W-1:0]   alloc_pc,
  output logic              alloc_ready,
  output logic [IDX_W-1:0]  alloc_idx,
  input  logic              cmp_valid,
  input  logic [IDX_W-1:0]  cmp_idx,
  input  logic [DATA_W-1:0] cmp_value,
  input  logic              cmp_exc,
  input  logic              cmp_misp,
  input  logic [PC_W-1:0]   cmp_target,
  output logic              rf_we,
  output logic [REG_W-1:0]  rf_addr,
  output logic [DATA_W-1:0] rf_data,
  output logic              redirect_valid,
  output logic [1:0]        redirect_cause,
  output logic [PC_W-1:0]   redirect_pc
);
  import rob_pkg::*;

  // distance of slot s from the oldest slot h, in program order
  function automatic logic [IDX_W:0] ring_age(input logic [IDX_W-1:0] s,
                                               input logic [IDX_W-1:0] h);
    return (s >= h) ? ({1'b0, s} - {1'b0, h})
                    : ({1'b0, s} + (IDX_W+1)'(DEPTH) - {1'b0, h});
  endfunction

  logic [IDX_W-1:0]  head, tail;
  logic              full, empty;
  logic [DEPTH-1:0]  slot_valid, kill;
  logic              hd_done, hd_exc;
  logic [REG_W-1:0]  hd_dest;
  logic [DATA_W-1:0] hd_value;
  logic [PC_W-1:0]   hd_pc;

  // named internal events
  logic head_live, fault_flush, retire, cmp_ok, branch_flush, alloc_fire;

  assign head_live    = slot_valid[head];
  assign fault_flush  = head_live & hd_done & hd_exc;
  assign retire       = head_live & hd_done & ~hd_exc;
  assign cmp_ok       = cmp_valid & slot_valid[cmp_idx] & ~fault_flush;
  assign branch_flush = cmp_ok & cmp_misp;
  assign alloc_ready  = ~full & ~fault_flush & ~branch_flush;
  assign alloc_fire   = alloc_valid & alloc_ready;
  assign alloc_idx    = tail;

  for (genvar g = 0; g < DEPTH; g++) begin : g_kill
    assign kill[g] = fault_flush |
      (branch_flush & (ring_age(IDX_W'(g), head) > ring_age(cmp_idx, head)));
  end

  rob_ptrs #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_ptrs (
    .clk(clk), .rst_n(rst_n),
    .adv_head(retire), .adv_tail(alloc_fire),
    .flush_all(fault_flush), .trim(branch_flush), .trim_idx(cmp_idx),
    .head(head), .tail(tail), .full(full), .empty(empty)
  );

  rob_slots #(.DEPTH(DEPTH), .DATA_W(DATA_W), .REG_W(REG_W), .PC_W(PC_W),
              .IDX_W(IDX_W)) u_slots (
    .clk(clk), .rst_n(rst_n),
    .alloc_we(alloc_fire), .alloc_idx(tail),
    .alloc_dest(alloc_dest), .alloc_pc(alloc_pc),
    .cmp_we(cmp_ok), .cmp_idx(cmp_idx), .cmp_value(cmp_value), .cmp_exc(cmp_exc),
    .free_we(retire), .free_idx(head), .kill(kill), .rd_idx(head),
    .slot_valid(slot_valid),
    .rd_done(hd_done), .rd_exc(hd_exc), .rd_dest(hd_dest),
    .rd_value(hd_value), .rd_pc(hd_pc)
  );

  assign rf_we          = retire;
  assign rf_addr        = hd_dest;
  assign rf_data        = hd_value;
  assign redirect_valid = fault_flush | branch_flush;
  assign redirect_cause = fault_flush  ? REDIR_FAULT :
                          branch_flush ? REDIR_BRANCH : REDIR_NONE;
  assign redirect_pc    = fault_flush ? hd_pc : cmp_target;

  // R7: a fault leaves the ring empty with tail pulled back to the head
  p_fault_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fault_flush |=> (slot_valid == '0) && (alloc_idx == $past(head)));
  // R8: a mispredict trims the tail to just past the branch slot
  p_branch_trims_r8: assert property (@(posedge clk) disable iff (!rst_n)
    branch_flush |=> (alloc_idx == (($past(cmp_idx) == IDX_W'(DEPTH-1)) ? '0
                                    : $past(cmp_idx) + 1'b1)));
  // R8: the mispredicted branch itself survives the trim
  p_branch_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    branch_flush |=> slot_valid[$past(cmp_idx)]);
  // R5: the oldest pointer moves only on a commit
  p_head_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !rf_we |=> $stable(head));
  // R3: a full ring stays full unless something leaves it
  p_full_sticks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !rf_we && !redirect_valid) |=> full);
  // R10: fault and mispredict are never reported together
  p_one_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |-> $onehot0({fault_flush, branch_flush}));
endmodule

// File: tb/sim_rob_core.sv
module sim_rob_core;
  localparam int N = 8;
  localparam int DW = 32;
  localparam int RW = 5;
  localparam int PW = 32;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic alloc_valid = 1'b0;
  logic [RW-1:0] alloc_dest = '0;
  logic [PW-1:0] alloc_pc = '0;
  logic alloc_ready;
  logic [IW-1:0] alloc_idx;
  logic cmp_valid = 1'b0;
  logic [IW-1:0] cmp_idx = '0;
  logic [DW-1:0] cmp_value = '0;
  logic cmp_exc = 1'b0, cmp_misp = 1'b0;
  logic [PW-1:0] cmp_target = '0;
  logic rf_we;
  logic [RW-1:0] rf_addr;
  logic [DW-1:0] rf_data;
  logic redirect_valid;
  logic [1:0] redirect_cause;
  logic [PW-1:0] redirect_pc;

  always #10 clk = ~clk;

  rob_core #(.DEPTH(N), .DATA_W(DW), .REG_W(RW), .PC_W(PW)) u0 (.*);

  int tests = 0, fails = 0;
  bit done_flag = 0;

  // bench model of the ring
  bit m_valid[N], m_done[N], m_exc[N];
  logic [RW-1:0] m_dest[N];
  logic [DW-1:0] m_val[N];
  logic [PW-1:0] m_pc[N];
  int m_head = 0, m_tail = 0;
  int pc_seq = 32'h1000;

  function automatic int age(int s, int h);
    return (s - h + N) % N;
  endfunction

  task automatic step(string tag, bit av, bit cv, int ci, logic [DW-1:0] val,
                      bit ce, bit cm, logic [PW-1:0] tgt);
    bit fault, ret, cok, bm, full, rdy, rv;
    int h, ecause;
    logic [PW-1:0] epc;
    logic [RW-1:0] d;
    alloc_valid = av; d = RW'($urandom); alloc_dest = d;
    alloc_pc = PW'(pc_seq); pc_seq += 4;
    cmp_valid = cv; cmp_idx = IW'(ci); cmp_value = val;
    cmp_exc = ce; cmp_misp = cm; cmp_target = tgt;
    #2;
    h = m_head;
    fault = m_valid[h] && m_done[h] && m_exc[h];
    ret = m_valid[h] && m_done[h] && !m_exc[h];
    cok = cv && m_valid[ci] && !fault;
    bm = cok && cm;
    full = ((m_tail + 1) % N) == m_head;
    rdy = !full && !fault && !bm;
    rv = fault || bm;
    ecause = fault ? 1 : (bm ? 2 : 0);
    epc = fault ? m_pc[h] : tgt;
    tests++;
    if (alloc_ready !== rdy || alloc_idx !== IW'(m_tail) || rf_we !== ret ||
        (ret && (rf_addr !== m_dest[h] || rf_data !== m_val[h])) ||
        redirect_valid !== rv ||
        (rv && (redirect_cause !== 2'(ecause) || redirect_pc !== epc))) begin
      fails++;
      $display("FAIL %s: got rdy=%0b idx=%0d we=%0b addr=%0d data=%h rv=%0b cause=%0d pc=%h; exp rdy=%0b idx=%0d we=%0b addr=%0d data=%h rv=%0b cause=%0d pc=%h",
        tag, alloc_ready, alloc_idx, rf_we, rf_addr, rf_data, redirect_valid,
        redirect_cause, redirect_pc, rdy, m_tail, ret, m_dest[h], m_val[h],
        rv, ecause, epc);
    end
    @(posedge clk);
    if (fault) begin
      for (int i = 0; i < N; i++) m_valid[i] = 0;
      m_tail = m_head;
    end else begin
      if (ret) begin m_valid[h] = 0; m_head = (h + 1) % N; end
      if (cok) begin m_done[ci] = 1; m_exc[ci] = ce; m_val[ci] = val; end
      if (bm) begin
        for (int i = 0; i < N; i++)
          if (age(i, h) > age(ci, h)) m_valid[i] = 0;
        m_tail = (ci + 1) % N;
      end else if (av && rdy) begin
        m_valid[m_tail] = 1; m_done[m_tail] = 0; m_exc[m_tail] = 0;
        m_dest[m_tail] = d; m_pc[m_tail] = PW'(pc_seq - 4);
        m_tail = (m_tail + 1) % N;
      end
    end
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    step("R1", 0, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < N - 1; i++) step("R2", 1, 0, 0, 0, 0, 0, 0);
    step("R3", 1, 0, 0, 0, 0, 0, 0);
    step("R6", 1, 1, 3, 32'h33, 0, 0, 0);
    step("R4", 1, 1, 0, 32'h10, 0, 0, 0);
    step("R3", 1, 0, 0, 0, 0, 0, 0);
    step("R6", 0, 0, 0, 0, 0, 0, 0);
    step("R6", 0, 1, 1, 32'h11, 0, 0, 0);
    step("R5", 0, 1, 2, 32'h22, 0, 0, 0);
    step("R5", 0, 0, 0, 0, 0, 0, 0);
    step("R5", 0, 0, 0, 0, 0, 0, 0);
    step("R8", 0, 1, 4, 32'h44, 0, 1, 32'h400);
    step("R9", 0, 1, 6, 32'h66, 0, 1, 32'h600);
    step("R8", 0, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 3; i++) step("R2", 1, 0, 0, 0, 0, 0, 0);
    step("R7", 0, 1, 5, 32'h55, 1, 0, 0);
    step("R10", 0, 1, 7, 32'h77, 0, 1, 32'h700);
    step("R7", 0, 0, 0, 0, 0, 0, 0);
    step("R9", 0, 1, 6, 32'h99, 0, 0, 0);
    step("R9", 0, 0, 0, 0, 0, 0, 0);
    for (int c = 0; c < 4000; c++) begin
      bit cv, ce, cm; int ci, st;
      cv = 0; ci = 0; ce = 0; cm = 0;
      st = $urandom % N;
      if ($urandom % 10 < 6)
        for (int k = 0; k < N; k++) begin
          int s = (st + k) % N;
          if (!cv && m_valid[s] && !m_done[s]) begin cv = 1; ci = s; end
        end
      if ($urandom % 12 == 0) begin cv = 1; ci = $urandom % N; end
      if (cv) begin
        ce = ($urandom % 20 == 0);
        cm = !ce && ($urandom % 25 == 0);
      end
      step("R5", ($urandom % 3) != 0, cv, ci, $urandom, ce, cm, $urandom);
    end
    done_flag = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      fails++;
      $display("FAIL watchdog: got hang, exp completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule